// File: doc/BRIEF.md
# Pipelined Configurable Routing Switch Node

This block is one routing node of a soft reconfigurable overlay built from ordinary logic. It has four sides, north, east, south and west. Each side has an incoming data track and an outgoing data track, all `DATA_W` bits wide. Each outgoing track is fed by a multiplexer. The multiplexer picks one of the incoming tracks of the three other sides, or it drives nothing. Every choice comes from configuration bits and never from the data itself.

Behind each multiplexer sits an optional output register. The register breaks combinational loops when nodes are chained and shortens the path through cascaded multiplexers. After the register comes a realignment delay line with a selectable depth of 0 to `MAX_DELAY` cycles. A placer uses it to pad short routes so that converging routes arrive with equal register counts.

Configuration enters bit-serially through a shift chain while `cfgEn` is high. The new setting is applied as one step when `cfgEn` drops. Data keeps flowing under the old setting while a new one is being shifted in.

Top module: `pipe_switch_node`

## Requirements
- R1: While `rst` is high at a clock edge, the node clears all configuration bits, the shift chain, the output registers and the delay stages. After that edge every outgoing track and `cfgOut` read zero, whatever the inputs are.
- R2: The sides are indexed north=0, east=1, south=2, west=3. The 2-bit source code of side s has these meanings: code 0 drives zero, and code c in 1..3 selects the incoming track of side (s+c) mod 4. For example, code 1 on north selects east, and code 3 on north selects west.
- R3: When a side's register-enable bit is 1, one cycle of latency is added to that side's path. When it is 0, no latency is added.
- R4: A delay field value d in 0..`MAX_DELAY` adds exactly d cycles of latency after the register stage. A value of 0 is a direct pass-through.
- R5: A delay field value above `MAX_DELAY` behaves as `MAX_DELAY`.
- R6: Each clock edge with `cfgEn` high shifts `cfgIn` into a chain of 4·(3+DLY_W) bits. `cfgOut` is the chain's most significant bit, so `cfgOut` repeats `cfgIn` one chain length later. Side s owns chain bits [s·W+W-1 : s·W], where W = 3+DLY_W. Within that word, bits [1:0] are the source code, bit [2] is the register enable, and bits [W-1:3] are the delay field. The first bit shifted in ends at the top of the west word.
- R7: While `cfgEn` is high, the active configuration does not change, and the outgoing tracks keep following the previous configuration.
- R8: The first clock edge at which `cfgEn` is sampled low after having been high makes the chain contents active. That same edge clears every output register and delay stage, so a side with latency L reads zero for L cycles after the switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgEn | input | 1 | Shift enable of the configuration chain; its falling edge applies the chain |
| cfgIn | input | 1 | Serial configuration data in |
| cfgOut | output | 1 | Serial configuration data out (chain MSB) |
| northIn | input | DATA_W | Incoming north track |
| eastIn | input | DATA_W | Incoming east track |
| southIn | input | DATA_W | Incoming south track |
| westIn | input | DATA_W | Incoming west track |
| northOut | output | DATA_W | Outgoing north track |
| eastOut | output | DATA_W | Outgoing east track |
| southOut | output | DATA_W | Outgoing south track |
| westOut | output | DATA_W | Outgoing west track |

## Verification
Two functions overlap in time. A new configuration is shifted in while data keeps flowing, and the old setting is still routing during that shift. The commit edge then also flushes the data that is in flight in the registers and delay stages. The bench keeps fresh random words on all four inputs during every shift cycle and every commit cycle. A cycle-accurate model of the chain and the latency holds the old routing until the commit edge. From that edge on, the model expects zeros for exactly the new latency before the newly selected track appears. Every source, register and delay combination, including delay codes above the limit, is applied to every side.

// File: rtl/sbox_pkg.sv
package sbox_pkg;

  // Side indices; source code c on side s selects side (s+c) mod 4
  localparam int SIDE_N = 0;
  localparam int SIDE_E = 1;
  localparam int SIDE_S = 2;
  localparam int SIDE_W = 3;
  localparam int NUM_SIDES = 4;

  // Strobes from the configuration control to the datapath
  typedef struct packed {
    logic clear;  // synchronous reset of all data state
    logic flush;  // new configuration applied this edge
  } cfgStrobe_t;

endpackage

// File: rtl/sbox_ctrl.sv
module sbox_ctrl
  import sbox_pkg::*;
#(
  parameter int CHAIN_W = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfgEn,
  input  logic               cfgIn,
  output logic               cfgOut,
  output cfgStrobe_t         strobe,
  output logic [CHAIN_W-1:0] activeCfg
);

  logic [CHAIN_W-1:0] chainQ;
  logic               cfgEnQ;
  logic               commit;

  assign commit = cfgEnQ & ~cfgEn;

  always_ff @(posedge clk) begin
    if (rst) begin
      chainQ    <= '0;
      activeCfg <= '0;
      cfgEnQ    <= 1'b0;
    end else begin
      cfgEnQ <= cfgEn;
      if (cfgEn) chainQ <= {chainQ[CHAIN_W-2:0], cfgIn};
      if (commit) activeCfg <= chainQ;
    end
  end

  assign cfgOut = chainQ[CHAIN_W-1];

  always_comb begin
    strobe       = '0;
    strobe.clear = rst;
    strobe.flush = commit;
  end

  // R7
  hold_cfg_chk: assert property (@(posedge clk) disable iff (rst)
    cfgEn |=> $stable(activeCfg));

  // R8
  commit_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cfgEn) |=> (activeCfg == $past(chainQ)));

endmodule

// File: rtl/sbox_lane.sv
module sbox_lane #(
  parameter int DATA_W    = 16,
  parameter int MAX_DELAY = 4,
  parameter int DLY_W     = 3
) (
  input  logic                  clk,
  input  logic                  clear,
  input  logic                  flush,
  input  logic [2:0][DATA_W-1:0] cand,
  input  logic [1:0]            srcSel,
  input  logic                  regEn,
  input  logic [DLY_W-1:0]      dlySel,
  output logic [DATA_W-1:0]     laneOut
);

  localparam logic [DLY_W-1:0] MAX_D = DLY_W'(MAX_DELAY);

  logic [DATA_W-1:0] muxOut;
  logic [DATA_W-1:0] regQ;
  logic [DATA_W-1:0] preDly;
  logic [DLY_W-1:0]  effDly;
  logic [DATA_W-1:0] stage [MAX_DELAY];

  always_comb begin
    unique case (srcSel)
      2'd1:    muxOut = cand[0];
      2'd2:    muxOut = cand[1];
      2'd3:    muxOut = cand[2];
      default: muxOut = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (clear || flush) regQ <= '0;
    else                regQ <= muxOut;
  end

  assign preDly = regEn ? regQ : muxOut;
  assign effDly = (dlySel > MAX_D) ? MAX_D : dlySel;

  always_ff @(posedge clk) begin
    if (clear || flush) begin
      for (int i = 0; i < MAX_DELAY; i++) stage[i] <= '0;
    end else begin
      stage[0] <= preDly;
      for (int i = 1; i < MAX_DELAY; i++) stage[i] <= stage[i-1];
    end
  end

  always_comb begin
    laneOut = preDly;
    for (int i = 0; i < MAX_DELAY; i++)
      if (effDly == DLY_W'(i + 1)) laneOut = stage[i];
  end

  // R2
  sel_off_chk: assert property (@(posedge clk) disable iff (clear)
    (srcSel == 2'd0 && !regEn && dlySel == '0) |-> (laneOut == '0));

  // R3
  reg_latency_chk: assert property (@(posedge clk) disable iff (clear)
    (!flush && regEn && dlySel == '0) |=> (laneOut == $past(muxOut)));

  // R4
  dly_one_chk: assert property (@(posedge clk) disable iff (clear)
    (!flush && !regEn && dlySel == DLY_W'(1)) |=> (laneOut == $past(muxOut)));

  // R8
  flush_clear_chk: assert property (@(posedge clk) disable iff (clear)
    flush |=> (!(regEn || dlySel != '0) || laneOut == '0));

endmodule

// File: rtl/sbox_datapath.sv
module sbox_datapath
  import sbox_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int MAX_DELAY = 4,
  parameter int DLY_W     = 3,
  parameter int WORD_W    = 6
) (
  input  logic                            clk,
  input  cfgStrobe_t                      strobe,
  input  logic [NUM_SIDES*WORD_W-1:0]     activeCfg,
  input  logic [NUM_SIDES-1:0][DATA_W-1:0] trackIn,
  output logic [NUM_SIDES-1:0][DATA_W-1:0] trackOut
);

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    logic [WORD_W-1:0]      word;
    logic [2:0][DATA_W-1:0] cand;

    assign word = activeCfg[s*WORD_W +: WORD_W];

    for (genvar k = 0; k < 3; k++) begin : g_cand
      assign cand[k] = trackIn[(s + k + 1) % NUM_SIDES];
    end

    sbox_lane #(
      .DATA_W   (DATA_W),
      .MAX_DELAY(MAX_DELAY),
      .DLY_W    (DLY_W)
    ) lane_i (
      .clk    (clk),
      .clear  (strobe.clear),
      .flush  (strobe.flush),
      .cand   (cand),
      .srcSel (word[1:0]),
      .regEn  (word[2]),
      .dlySel (word[WORD_W-1:3]),
      .laneOut(trackOut[s])
    );
  end

endmodule

// File: rtl/pipe_switch_node.sv
module pipe_switch_node
  import sbox_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int MAX_DELAY = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgEn,
  input  logic              cfgIn,
  output logic              cfgOut,
  input  logic [DATA_W-1:0] northIn,
  input  logic [DATA_W-1:0] eastIn,
  input  logic [DATA_W-1:0] southIn,
  input  logic [DATA_W-1:0] westIn,
  output logic [DATA_W-1:0] northOut,
  output logic [DATA_W-1:0] eastOut,
  output logic [DATA_W-1:0] southOut,
  output logic [DATA_W-1:0] westOut
);

  localparam int DLY_W   = $clog2(MAX_DELAY + 1);
  localparam int WORD_W  = 3 + DLY_W;
  localparam int CHAIN_W = NUM_SIDES * WORD_W;

  cfgStrobe_t                       strobe;
  logic [CHAIN_W-1:0]               activeCfg;
  logic [NUM_SIDES-1:0][DATA_W-1:0] trackIn;
  logic [NUM_SIDES-1:0][DATA_W-1:0] trackOut;

  assign trackIn[SIDE_N] = northIn;
  assign trackIn[SIDE_E] = eastIn;
  assign trackIn[SIDE_S] = southIn;
  assign trackIn[SIDE_W] = westIn;

  assign northOut = trackOut[SIDE_N];
  assign eastOut  = trackOut[SIDE_E];
  assign southOut = trackOut[SIDE_S];
  assign westOut  = trackOut[SIDE_W];

  sbox_ctrl #(.CHAIN_W(CHAIN_W)) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .cfgEn    (cfgEn),
    .cfgIn    (cfgIn),
    .cfgOut   (cfgOut),
    .strobe   (strobe),
    .activeCfg(activeCfg)
  );

  sbox_datapath #(
    .DATA_W   (DATA_W),
    .MAX_DELAY(MAX_DELAY),
    .DLY_W    (DLY_W),
    .WORD_W   (WORD_W)
  ) dp_i (
    .clk      (clk),
    .strobe   (strobe),
    .activeCfg(activeCfg),
    .trackIn  (trackIn),
    .trackOut (trackOut)
  );

endmodule

// File: tb/pipe_switch_node_tb_top.sv
`timescale 1ns/1ps
module pipe_switch_node_tb_top;

  localparam int DW   = 16;
  localparam int MAXD = 4;
  localparam int DLYW = 3;
  localparam int WW   = 3 + DLYW;
  localparam int L    = 4 * WW;
  localparam int NCOMBO = 48;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfgEn = 1'b0;
  logic cfgIn = 1'b0;
  logic cfgOut;
  logic [DW-1:0] nIn = '0, eIn = '0, sIn = '0, wIn = '0;
  logic [DW-1:0] nOut, eOut, sOut, wOut;

  int nChecks = 0;
  int nFail = 0;
  int gk = 0;
  int k0 = 0;
  logic prevEn = 1'b0;
  logic [L-1:0] mChain = '0;
  logic [L-1:0] mCfg = '0;
  logic [DW-1:0] hist [8][4];

  always #2.5 clk = ~clk;

  pipe_switch_node #(.DATA_W(DW), .MAX_DELAY(MAXD)) dut_i (
    .clk(clk), .rst(rst), .cfgEn(cfgEn), .cfgIn(cfgIn), .cfgOut(cfgOut),
    .northIn(nIn), .eastIn(eIn), .southIn(sIn), .westIn(wIn),
    .northOut(nOut), .eastOut(eOut), .southOut(sOut), .westOut(wOut)
  );

  function automatic logic [DW-1:0] getOut(int s);
    case (s)
      0: return nOut;
      1: return eOut;
      2: return sOut;
      default: return wOut;
    endcase
  endfunction

  task automatic chk(string tag, int s, logic [DW-1:0] act, logic [DW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s side %0d cycle %0d: actual %h expected %h", tag, s, gk, act, exp);
    end
  endtask

  // Reference: latency = regEn + clamped delay; zero while flushed or code 0
  task automatic checkOutputs();
    for (int s = 0; s < 4; s++) begin
      logic [WW-1:0] w;
      int sel, rg, d, lat;
      logic [DW-1:0] exp;
      string tag;
      w   = mCfg[s*WW +: WW];
      sel = int'(w[1:0]);
      rg  = int'(w[2]);
      d   = int'(w[WW-1:3]);
      if (d > MAXD) d = MAXD;
      lat = rg + d;
      if (sel == 0 || gk - lat < k0) exp = '0;
      else exp = hist[(gk - lat) % 8][(s + sel) % 4];
      if (cfgEn) tag = "R7";
      else if (gk - lat < k0 && sel != 0) tag = "R8";
      else if (sel == 0) tag = "R2";
      else if (int'(w[WW-1:3]) > MAXD) tag = "R5";
      else if (d > 0) tag = "R4";
      else if (rg != 0) tag = "R3";
      else tag = "R2";
      chk(tag, s, getOut(s), exp);
    end
    chk("R6", 4, DW'(cfgOut), DW'(mChain[L-1]));
  endtask

  // One cycle: drive data, check after settling, take the edge, update model
  task automatic step();
    for (int s = 0; s < 4; s++) hist[gk % 8][s] = DW'($urandom);
    nIn = hist[gk % 8][0];
    eIn = hist[gk % 8][1];
    sIn = hist[gk % 8][2];
    wIn = hist[gk % 8][3];
    #1;
    if (!rst) checkOutputs();
    @(posedge clk);
    if (rst) begin
      mChain = '0; mCfg = '0; prevEn = 1'b0; k0 = gk + 1;
    end else begin
      if (prevEn && !cfgEn) begin
        mCfg = mChain; k0 = gk + 1;
      end
      if (cfgEn) mChain = {mChain[L-2:0], cfgIn};
      prevEn = cfgEn;
    end
    gk++;
    @(negedge clk);
  endtask

  function automatic logic [WW-1:0] mkWord(int sel, int rg, int d);
    return {DLYW'(d), 1'(rg), 2'(sel)};
  endfunction

  function automatic logic [WW-1:0] comboWord(int c);
    int di;
    di = c / 8;
    return mkWord(c % 4, (c / 4) % 2, (di == 5) ? 7 : di);
  endfunction

  task automatic loadCfg(logic [L-1:0] cfg);
    for (int i = L - 1; i >= 0; i--) begin
      cfgEn = 1'b1; cfgIn = cfg[i];
      step();
    end
    cfgEn = 1'b0; cfgIn = 1'b0;
    step();
  endtask

  task automatic tReset();
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
    #1;
    for (int s = 0; s < 4; s++) chk("R1", s, getOut(s), '0);
    chk("R1", 4, DW'(cfgOut), '0);
    for (int i = 0; i < 4; i++) step();
  endtask

  task automatic tChainEcho();
    cfgEn = 1'b1;
    for (int i = 0; i < L; i++) begin
      cfgIn = 1'($urandom);
      step();
    end
    loadCfg({mkWord(1, 0, 0), mkWord(2, 1, 0), mkWord(3, 0, 2), mkWord(1, 1, 3)});
    for (int i = 0; i < 8; i++) step();
  endtask

  task automatic tAllCombos();
    for (int c = 0; c < NCOMBO; c++) begin
      logic [L-1:0] cfg;
      for (int s = 0; s < 4; s++) cfg[s*WW +: WW] = comboWord((c + 11 * s) % NCOMBO);
      loadCfg(cfg);
      for (int i = 0; i < 8; i++) step();
    end
  endtask

  task automatic tMaxLatencyRoute();
    loadCfg({mkWord(3, 1, 7), mkWord(2, 1, MAXD), mkWord(1, 1, 5), mkWord(2, 0, 0)});
    for (int i = 0; i < 10; i++) step();
  endtask

  task automatic tResetMidRun();
    loadCfg({mkWord(2, 1, 2), mkWord(1, 0, 1), mkWord(3, 1, 0), mkWord(1, 0, 0)});
    for (int i = 0; i < 3; i++) step();
    tReset();
  endtask

  initial begin
    @(negedge clk);
    tReset();
    tChainEcho();
    tAllCombos();
    tMaxLatencyRoute();
    tResetMidRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule